// File: doc/BRIEF.md
# Shared-Bus Accumulator Computer

This block is a complete small stored-program computer. A 4-bit program counter, a memory address register, a 16-word by 8-bit RAM, an instruction register, an accumulator, a second operand register, an add/subtract unit, a two-bit flag register and an output register all exchange data over one 8-bit bus. In any cycle, exactly one unit or none drives that bus. An internal sequencer steps each instruction through a fixed series of T-states. Each T-state raises the drive and load strobes that the instruction needs at that step.

The block has two modes. While `prog_mode_i` is high, the RAM is filled from the external address, data and write-strobe inputs, and the machine does not run. When `prog_mode_i` goes low, the machine fetches from address 0 and executes until it reaches a halt instruction. In execution mode the RAM switch inputs are ignored.

Each instruction byte holds a 4-bit opcode in bits 7:4 and a 4-bit operand in bits 3:0.

| Opcode | Bits 7:4 | Action |
|---|---|---|
| load | 0000 | Operand is a RAM address; the word there is loaded into the accumulator |
| add | 0001 | Word at the operand address is added to the accumulator |
| subtract | 0010 | Word at the operand address is subtracted from the accumulator |
| output | 1110 | Accumulator is copied to the output register; operand is ignored |
| halt | 1111 | Machine stops; operand is ignored |

Top module: `acc_bus_cpu`

## Requirements
- R1: While `rst_ni` is low, the block clears the program counter, every register, the flags, the T-state counter and the halted state: `out_o`=0, `halted_o`=0, `zero_o`=0, `carry_o`=0. Reset leaves the RAM contents unchanged.
- R2: While `prog_mode_i`=1, a rising clock edge with `prog_we_i`=1 writes `prog_data_i` into the RAM word at `prog_addr_i`. In this mode the sequencer does not advance, and the outputs stay unchanged.
- R3: While `prog_mode_i`=0, `prog_we_i`, `prog_addr_i` and `prog_data_i` have no effect on the RAM.
- R4: Execution starts at address 0 after reset, and the program counter advances by one for each instruction fetched.
- R5: The opcode encodings are those given in the table above. The operand in bits 3:0 is the RAM address for load, add and subtract.
- R6: The add instruction writes the low 8 bits of A+M to the accumulator. The zero flag is set when that result is 0, and the carry flag is the carry-out of the 8-bit addition.
- R7: The subtract instruction computes A + ~M + 1. The carry flag is the carry-out of that addition (1 when no borrow occurs), and the zero flag is set when the result is 0.
- R8: The flags change only on add and subtract. Load, output and halt leave them unchanged.
- R9: The output instruction copies the accumulator to `out_o`. Work done after the last output instruction does not change `out_o`.
- R10: After a halt instruction, `halted_o`=1, no control strobe is asserted, and `out_o` and the flags stay unchanged until reset.
- R11: At most one unit drives the shared bus in any cycle.
- R12: Every instruction starts with two fetch states. Output and halt take 3 cycles, load takes 4, and add and subtract take 5. A halt at address 0 raises `halted_o` after the third rising edge in execution mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| prog_mode_i | input | 1 | 1: program mode (RAM fill, machine idle); 0: execute |
| prog_addr_i | input | 4 | RAM address for programming |
| prog_data_i | input | 8 | RAM data for programming |
| prog_we_i | input | 1 | RAM write strobe, honoured only in program mode |
| out_o | output | 8 | Output register |
| halted_o | output | 1 | High once a halt instruction has executed |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Carry flag |

## Verification
The bench builds the block with its default 8-bit data width and 4-bit address width. With these values, every one of the 16 RAM words can be programmed and then observed, the reference program of load, add, subtract, output, add and halt fits in full, and 0x80+0x80 sets both flags at once. The directed programs cover the following cases:
- Add with carry-out.
- Subtract with and without borrow.
- Flags held across a later load.
- A halt at address 0.
- Programming strobes driven while the machine runs.
- A second run after reset with no reload.

Each case is observed only through the output, flag and halted ports, together with cycle counts.

// File: rtl/acb_pkg.sv
package acb_pkg;
  localparam int OP_W = 4;
  localparam int T_W  = 3;

  localparam logic [OP_W-1:0] OP_LOAD = 4'b0000;
  localparam logic [OP_W-1:0] OP_ADD  = 4'b0001;
  localparam logic [OP_W-1:0] OP_SUB  = 4'b0010;
  localparam logic [OP_W-1:0] OP_SHOW = 4'b1110;
  localparam logic [OP_W-1:0] OP_STOP = 4'b1111;

  typedef struct packed {
    logic stop;     // enter halted state
    logic mar_ld;
    logic ram_drv;
    logic ir_drv;   // operand nibble onto bus
    logic ir_ld;
    logic acc_ld;
    logic acc_drv;
    logic alu_drv;
    logic alu_sub;
    logic b_ld;
    logic out_ld;
    logic pc_inc;
    logic pc_drv;
    logic flg_ld;
  } ctrl_t;
endpackage

// File: rtl/acb_ram.sv
module acb_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/acb_alu.sv
module acb_alu #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              carry_o,
  output logic              zero_o
);
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   full;

  assign b_eff   = sub_i ? ~b_i : b_i;
  assign full    = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_i};
  assign sum_o   = full[DATA_W-1:0];
  assign carry_o = full[DATA_W];
  assign zero_o  = (full[DATA_W-1:0] == '0);
endmodule

// File: rtl/acb_seq.sv
module acb_seq
  import acb_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic [OP_W-1:0] op_i,
  output ctrl_t           ctrl_o,
  output logic            halted_o
);
  logic [T_W-1:0] t_q;
  logic           halted_q;
  logic           last;
  logic           live;

  assign live = run_i && !halted_q;

  always_comb begin
    ctrl_o = '0;
    last   = 1'b0;
    if (live) begin
      unique case (t_q)
        3'd0: begin ctrl_o.pc_drv = 1'b1; ctrl_o.mar_ld = 1'b1; end
        3'd1: begin ctrl_o.ram_drv = 1'b1; ctrl_o.ir_ld = 1'b1; ctrl_o.pc_inc = 1'b1; end
        3'd2: begin
          if (op_i == OP_LOAD || op_i == OP_ADD || op_i == OP_SUB) begin
            ctrl_o.ir_drv = 1'b1; ctrl_o.mar_ld = 1'b1;
          end else if (op_i == OP_SHOW) begin
            ctrl_o.acc_drv = 1'b1; ctrl_o.out_ld = 1'b1; last = 1'b1;
          end else if (op_i == OP_STOP) begin
            ctrl_o.stop = 1'b1; last = 1'b1;
          end else begin
            last = 1'b1;  // unused opcode: no operation
          end
        end
        3'd3: begin
          ctrl_o.ram_drv = 1'b1;
          if (op_i == OP_LOAD) begin
            ctrl_o.acc_ld = 1'b1; last = 1'b1;
          end else begin
            ctrl_o.b_ld = 1'b1;
          end
        end
        3'd4: begin
          ctrl_o.alu_drv = 1'b1; ctrl_o.acc_ld = 1'b1; ctrl_o.flg_ld = 1'b1;
          ctrl_o.alu_sub = (op_i == OP_SUB);
          last = 1'b1;
        end
        default: last = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q      <= '0;
      halted_q <= 1'b0;
    end else if (live) begin
      t_q <= last ? '0 : t_q + 1'b1;
      if (ctrl_o.stop) halted_q <= 1'b1;
    end
  end

  assign halted_o = halted_q;
endmodule

// File: rtl/acc_bus_cpu.sv
module acc_bus_cpu
  import acb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_mode_i,
  input  logic [ADDR_W-1:0] prog_addr_i,
  input  logic [DATA_W-1:0] prog_data_i,
  input  logic              prog_we_i,
  output logic [DATA_W-1:0] out_o,
  output logic              halted_o,
  output logic              zero_o,
  output logic              carry_o
);
  localparam int PAD_W = DATA_W - ADDR_W;

  ctrl_t             ctrl;
  logic [DATA_W-1:0] bus;
  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] ir_q, acc_q, b_q, out_q;
  logic [1:0]        flags_q;  // {carry, zero}
  logic [DATA_W-1:0] ram_rd, alu_sum;
  logic              alu_c, alu_z;

  acb_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (!prog_mode_i),
    .op_i     (ir_q[DATA_W-1 -: OP_W]),
    .ctrl_o   (ctrl),
    .halted_o (halted_o)
  );

  acb_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk_i   (clk_i),
    .we_i    (prog_mode_i && prog_we_i),
    .waddr_i (prog_addr_i),
    .wdata_i (prog_data_i),
    .raddr_i (mar_q),
    .rdata_o (ram_rd)
  );

  acb_alu #(.DATA_W(DATA_W)) u_alu (
    .a_i     (acc_q),
    .b_i     (b_q),
    .sub_i   (ctrl.alu_sub),
    .sum_o   (alu_sum),
    .carry_o (alu_c),
    .zero_o  (alu_z)
  );

  // AND-OR bus; sequencer guarantees a single driver
  assign bus = ({DATA_W{ctrl.pc_drv}}  & {{PAD_W{1'b0}}, pc_q})
             | ({DATA_W{ctrl.ram_drv}} & ram_rd)
             | ({DATA_W{ctrl.ir_drv}}  & {{PAD_W{1'b0}}, ir_q[ADDR_W-1:0]})
             | ({DATA_W{ctrl.acc_drv}} & acc_q)
             | ({DATA_W{ctrl.alu_drv}} & alu_sum);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      mar_q   <= '0;
      ir_q    <= '0;
      acc_q   <= '0;
      b_q     <= '0;
      out_q   <= '0;
      flags_q <= '0;
    end else begin
      if (ctrl.pc_inc) pc_q    <= pc_q + 1'b1;
      if (ctrl.mar_ld) mar_q   <= bus[ADDR_W-1:0];
      if (ctrl.ir_ld)  ir_q    <= bus;
      if (ctrl.acc_ld) acc_q   <= bus;
      if (ctrl.b_ld)   b_q     <= bus;
      if (ctrl.out_ld) out_q   <= bus;
      if (ctrl.flg_ld) flags_q <= {alu_c, alu_z};
    end
  end

  assign out_o   = out_q;
  assign carry_o = flags_q[1];
  assign zero_o  = flags_q[0];
endmodule

// File: rtl/acc_bus_cpu_chk.sv
module acc_bus_cpu_chk
  import acb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              prog_mode_i,
  input ctrl_t             ctrl_i,
  input logic [DATA_W-1:0] acc_i,
  input logic [DATA_W-1:0] out_i,
  input logic              halted_i,
  input logic              zero_i,
  input logic              carry_i
);
  p_one_driver_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctrl_i.pc_drv, ctrl_i.ram_drv, ctrl_i.ir_drv, ctrl_i.acc_drv, ctrl_i.alu_drv}));

  p_halt_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |-> (ctrl_i == '0));

  p_halt_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |=> (halted_i && $stable(out_i) && $stable(zero_i) && $stable(carry_i)));

  p_prog_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_mode_i |=> ($stable(out_i) && $stable(halted_i) && $stable(zero_i)));

  p_flags_alu_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i.flg_ld |=> ($stable(zero_i) && $stable(carry_i)));

  p_out_copy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.out_ld |=> (out_i == $past(acc_i)));

  p_out_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i.out_ld |=> $stable(out_i));
endmodule

bind acc_bus_cpu acc_bus_cpu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .prog_mode_i (prog_mode_i),
  .ctrl_i      (ctrl),
  .acc_i       (acc_q),
  .out_i       (out_o),
  .halted_i    (halted_o),
  .zero_i      (zero_o),
  .carry_i     (carry_o)
);

// File: tb/tb_acc_bus_cpu.sv
module tb_acc_bus_cpu;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       prog_mode_i;
  logic [3:0] prog_addr_i;
  logic [7:0] prog_data_i;
  logic       prog_we_i;
  logic [7:0] out_o;
  logic       halted_o, zero_o, carry_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [7:0] img [16];

  always #10ns clk_i = ~clk_i;

  acc_bus_cpu dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .prog_mode_i(prog_mode_i),
    .prog_addr_i(prog_addr_i), .prog_data_i(prog_data_i), .prog_we_i(prog_we_i),
    .out_o(out_o), .halted_o(halted_o), .zero_o(zero_o), .carry_o(carry_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_img();
    for (int i = 0; i < 16; i++) img[i] = 8'h00;
  endtask

  // reset held in program mode
  task automatic do_reset();
    @(negedge clk_i);
    prog_mode_i = 1'b1; prog_we_i = 1'b0; rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic load_img();
    for (int i = 0; i < 16; i++) begin
      @(negedge clk_i);
      prog_addr_i = 4'(i); prog_data_i = img[i]; prog_we_i = 1'b1;
    end
    @(negedge clk_i);
    prog_we_i = 1'b0;
  endtask

  // leave program mode, count edges until halted
  task automatic run(input int max_cyc, input bit poke, output int cyc);
    cyc = 0;
    prog_mode_i = 1'b0;
    while (cyc < max_cyc) begin
      if (poke) begin
        prog_we_i = 1'b1; prog_addr_i = 4'h9; prog_data_i = 8'hFF;
      end
      @(negedge clk_i);
      cyc++;
      if (halted_o) break;
    end
    prog_we_i = 1'b0;
  endtask

  task automatic demo_img();
    clear_img();
    img[0] = 8'h09; img[1] = 8'h1E; img[2] = 8'h2D;
    img[3] = 8'hE0; img[4] = 8'h1A; img[5] = 8'hF0;
    img[9] = 8'd16; img[10] = 8'hAA; img[13] = 8'd64; img[14] = 8'd127;
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk_i);
    chk("R1 out after reset", out_o, 0);
    chk("R1 halted after reset", halted_o, 0);
    chk("R1 flags after reset", {zero_o, carry_o}, 0);
  endtask

  task automatic t_demo();
    int cyc;
    demo_img();
    do_reset(); load_img();
    run(200, 1'b0, cyc);
    chk("R4 R5 R9 demo output", out_o, 79);
    chk("R10 demo halted", halted_o, 1);
    chk("R6 demo flags after last add", {zero_o, carry_o}, 0);
    chk("R12 demo cycle count", cyc, 25);
  endtask

  task automatic t_add_carry();
    int cyc;
    clear_img();
    img[0] = 8'h04; img[1] = 8'h15; img[2] = 8'hE0; img[3] = 8'hF0;
    img[4] = 8'h80; img[5] = 8'h80;
    do_reset(); load_img();
    run(200, 1'b0, cyc);
    chk("R6 wrapped sum", out_o, 0);
    chk("R6 zero flag", zero_o, 1);
    chk("R6 carry flag", carry_o, 1);
  endtask

  task automatic t_sub(input logic [7:0] a, input logic [7:0] b);
    int cyc;
    logic [8:0] full;
    clear_img();
    img[0] = 8'h04; img[1] = 8'h25; img[2] = 8'hE0; img[3] = 8'hF0;
    img[4] = a; img[5] = b;
    full = {1'b0, a} + {1'b0, ~b} + 9'd1;
    do_reset(); load_img();
    run(200, 1'b0, cyc);
    chk("R7 difference", out_o, int'(full[7:0]));
    chk("R7 carry flag", carry_o, int'(full[8]));
    chk("R7 zero flag", zero_o, int'(full[7:0] == 8'h00));
  endtask

  task automatic t_flags_hold();
    int cyc;
    clear_img();
    img[0] = 8'h05; img[1] = 8'h15; img[2] = 8'h06; img[3] = 8'hE0; img[4] = 8'hF0;
    img[5] = 8'h80; img[6] = 8'h33;
    do_reset(); load_img();
    run(200, 1'b0, cyc);
    chk("R8 out from later load", out_o, 8'h33);
    chk("R8 flags kept across load and output", {zero_o, carry_o}, 2'b11);
  endtask

  task automatic t_halt_first();
    int cyc;
    logic [7:0] o;
    clear_img();
    img[0] = 8'hF0;
    do_reset(); load_img();
    repeat (10) @(negedge clk_i);
    chk("R2 idle in program mode", halted_o, 0);
    chk("R2 out unchanged in program mode", out_o, 0);
    run(50, 1'b0, cyc);
    chk("R12 halt at address 0 cycles", cyc, 3);
    o = out_o;
    repeat (20) @(negedge clk_i);
    chk("R10 stays halted", halted_o, 1);
    chk("R10 out stable after halt", out_o, int'(o));
  endtask

  task automatic t_output_timing();
    int cyc;
    clear_img();
    img[0] = 8'hE0; img[1] = 8'hF0;
    do_reset(); load_img();
    run(50, 1'b0, cyc);
    chk("R12 output then halt cycles", cyc, 6);
  endtask

  task automatic t_switch_ignored();
    int cyc;
    demo_img();
    do_reset(); load_img();
    run(200, 1'b1, cyc);
    chk("R3 writes ignored while running", out_o, 79);
    do_reset();
    run(200, 1'b0, cyc);
    chk("R1 RAM kept across reset", out_o, 79);
    chk("R3 rerun halted", halted_o, 1);
  endtask

  initial begin
    rst_ni = 1'b0; prog_mode_i = 1'b1; prog_we_i = 1'b0;
    prog_addr_i = '0; prog_data_i = '0;
    t_reset();
    t_demo();
    t_add_carry();
    t_sub(8'd5, 8'd3);
    t_sub(8'd3, 8'd5);
    t_sub(8'd7, 8'd7);
    t_flags_hold();
    t_halt_first();
    t_output_timing();
    t_switch_ignored();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule